// File: doc/BRIEF.md
# Set-Associative Block Cache with LRU Replacement

This block is a small lookup cache of one-word blocks. It takes one block address per cycle and reports whether that block was already resident. Placement is set by one parameter, the number of ways. With one way the cache is direct mapped. With two ways it is two-way set associative. With as many ways as lines it is fully associative. The same logic serves all three.

The set is picked from the low bits of the block address. The tags of every way in that set are compared at the same time. If no way matches, the block is loaded from a simple built-in data model. An empty way is used before any resident block is evicted. If the set is full, the way untouched for the longest time is evicted. A running miss count is kept at the output. The block is meant for placement studies: the same address trace can be run against differently configured instances and their miss counts compared.

The line count and the way count must both be powers of two, with the ways dividing the lines.

Top module: `assoc_cache`

## Requirements
- R1: The set index is the block address modulo SETS, where SETS = LINES/WAYS. With the defaults LINES=4 and WAYS=2, addresses 0 and 2 share a set and addresses 0 and 1 do not.
- R2: An access hits when any valid way of its set holds the same tag. All ways of the set are compared in parallel, and at most one way ever matches.
- R3: A miss to a set with no empty way replaces the least recently used way of that set.
- R4: A miss to a set that still has an empty way fills an empty way and evicts nothing.
- R5: Every hit, and every fill, makes the touched way the most recently used way of its set.
- R6: An access presented with `req_valid` high at a rising edge has its result on `rsp_valid`/`rsp_hit`/`rsp_data` right after that edge. The result holds for one cycle. `rsp_valid` is low after any edge where `req_valid` was low, and an idle cycle changes no cache state.
- R7: `miss_count` rises by exactly one at the edge that registers a miss response. It does not change on a hit or on an idle cycle. It wraps modulo 2^CNT_W.
- R8: `rsp_data` carries the word stored for the block, on a hit and on a miss alike. The model sets that word to (address*37 + 5) mod 2^DATA_W.
- R9: Reset invalidates every way, clears `miss_count`, and drives `rsp_valid` low.
- R10: An access sees the state left by the access one cycle before it. Two back-to-back accesses to the same address give a miss or hit first, then a hit.
- R11: On four lines with the block address trace 0, 8, 0, 6, 8, run from reset, `miss_count` ends at 5 with one way, 4 with two ways and 3 with four ways.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_addr | input | ADDR_W | Block address of the access |
| rsp_valid | output | 1 | Registered result of the previous cycle's access is present |
| rsp_hit | output | 1 | That access found its block resident |
| rsp_data | output | DATA_W | Word of the accessed block |
| miss_count | output | CNT_W | Misses since reset |

## Verification
The hard case is when the registered result of one access and the lookup of the next access happen in the same cycle for the same set. The second lookup must see the fill or the recency change of the first. The bench provokes this with back-to-back accesses: repeated addresses and conflicting addresses in a narrow range, with idle cycles mixed in at random. Direct-mapped, two-way and fully associative instances receive the same stream. Each instance is compared every cycle against a behavioural recency-ordered list per set, so a stale lookup shows up as a wrong hit bit or a drifting miss count.

// File: rtl/cache_pkg.sv
package cache_pkg;
    // Width of an index over n items; never zero so that vectors stay legal.
    function automatic int unsigned idx_width(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Number of address bits consumed by set selection.
    function automatic int unsigned sel_bits(int unsigned n);
        return (n > 1) ? $clog2(n) : 0;
    endfunction
endpackage

// File: rtl/cache_tag_match.sv
module cache_tag_match #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 7,
    parameter int WAY_W = 1
) (
    input  logic [WAYS-1:0]            valid,
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]           probe,
    output logic [WAYS-1:0]            match,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way
);
    // One comparator per way, all evaluated in parallel.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = valid[w] && (tags[w] == probe);
    end

    assign hit = |match;

    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/cache_victim_pick.sv
module cache_victim_pick #(
    parameter int WAYS  = 2,
    parameter int WAY_W = 1
) (
    input  logic [WAYS-1:0]            valid,
    input  logic [WAYS-1:0][WAY_W-1:0] age,
    output logic [WAY_W-1:0]           victim
);
    logic found_empty;

    always_comb begin
        victim      = '0;
        found_empty = 1'b0;
        // Lowest-numbered empty way wins.
        for (int w = 0; w < WAYS; w++) begin
            if (!valid[w] && !found_empty) begin
                victim      = WAY_W'(w);
                found_empty = 1'b1;
            end
        end
        // Otherwise the way with the greatest age is the oldest.
        if (!found_empty) begin
            for (int w = 0; w < WAYS; w++) begin
                if (age[w] == WAY_W'(WAYS - 1)) victim = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/cache_fill_model.sv
module cache_fill_model #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    localparam logic [DATA_W-1:0] MUL = DATA_W'(37);
    localparam logic [DATA_W-1:0] OFS = DATA_W'(5);

    assign data = DATA_W'(addr) * MUL + OFS;
endmodule

// File: rtl/assoc_cache.sv
module assoc_cache
    import cache_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int LINES  = 4,
    parameter int WAYS   = 2,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_data,
    output logic [CNT_W-1:0]  miss_count
);
    localparam int SETS     = LINES / WAYS;
    localparam int SET_BITS = sel_bits(SETS);
    localparam int IDX_W    = idx_width(SETS);
    localparam int WAY_W    = idx_width(WAYS);
    localparam int TAG_W    = ADDR_W - SET_BITS;

    typedef struct packed {
        logic [LINES-1:0]             valid;
        logic [LINES-1:0][TAG_W-1:0]  tag;
        logic [LINES-1:0][DATA_W-1:0] data;
        logic [LINES-1:0][WAY_W-1:0]  age;
        logic                         rsp_valid;
        logic                         rsp_hit;
        logic [DATA_W-1:0]            rsp_data;
        logic [CNT_W-1:0]             misses;
    } state_t;

    state_t st_d, st_q;

    logic [IDX_W-1:0]             set_idx;
    logic [TAG_W-1:0]             req_tag;
    int                           base;
    logic [WAYS-1:0]              set_valid;
    logic [WAYS-1:0][TAG_W-1:0]   set_tag;
    logic [WAYS-1:0][DATA_W-1:0]  set_data;
    logic [WAYS-1:0][WAY_W-1:0]   set_age;
    logic [WAYS-1:0]              match_vec;
    logic                         hit;
    logic [WAY_W-1:0]             hit_way;
    logic [WAY_W-1:0]             victim_way;
    logic [WAY_W-1:0]             touch_way;
    logic [WAY_W-1:0]             touch_age;
    logic [DATA_W-1:0]            fill_data;

    // Set selection and tag split: modulo by a power of two.
    always_comb begin
        set_idx = (SETS > 1) ? req_addr[IDX_W-1:0] : '0;
        req_tag = TAG_W'(req_addr >> SET_BITS);
        base    = int'(set_idx) * WAYS;
        for (int w = 0; w < WAYS; w++) begin
            set_valid[w] = st_q.valid[base + w];
            set_tag[w]   = st_q.tag[base + w];
            set_data[w]  = st_q.data[base + w];
            set_age[w]   = st_q.age[base + w];
        end
    end

    cache_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
        .valid   (set_valid),
        .tags    (set_tag),
        .probe   (req_tag),
        .match   (match_vec),
        .hit     (hit),
        .hit_way (hit_way)
    );

    cache_victim_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
        .valid  (set_valid),
        .age    (set_age),
        .victim (victim_way)
    );

    cache_fill_model #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fill (
        .addr (req_addr),
        .data (fill_data)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = req_valid;
        st_d.rsp_hit   = 1'b0;
        touch_way      = hit ? hit_way : victim_way;
        touch_age      = set_age[touch_way];
        if (req_valid) begin
            st_d.rsp_hit = hit;
            // Recency update: touched way becomes youngest, younger ones age.
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way) begin
                    st_d.age[base + w] = '0;
                end else if (set_age[w] < touch_age) begin
                    st_d.age[base + w] = set_age[w] + 1'b1;
                end
            end
            if (hit) begin
                st_d.rsp_data = set_data[hit_way];
            end else begin
                st_d.rsp_data                            = fill_data;
                st_d.valid[base + int'(victim_way)]      = 1'b1;
                st_d.tag[base + int'(victim_way)]        = req_tag;
                st_d.data[base + int'(victim_way)]       = fill_data;
                st_d.misses                              = st_q.misses + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            // Ages start as a permutation so every set has a defined order.
            for (int l = 0; l < LINES; l++) begin
                st_q.age[l] <= WAY_W'(l % WAYS);
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid  = st_q.rsp_valid;
    assign rsp_hit    = st_q.rsp_hit;
    assign rsp_data   = st_q.rsp_data;
    assign miss_count = st_q.misses;

    // Result timing (R6)
    assert_rsp_follows_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_idle_no_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // Miss counting (R7)
    assert_miss_bumps_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (miss_count == CNT_W'($past(miss_count) + 1'b1)));
    assert_hit_keeps_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> $stable(miss_count));

    // Parallel compare never finds the same block twice (R2)
    assert_single_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $onehot0(match_vec));

    // Empty ways are used before eviction (R4)
    assert_empty_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !hit && !(&set_valid)) |-> !set_valid[victim_way]);

    // A repeated address right after an access must hit (R10)
    assert_repeat_hits_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req_valid) && req_valid && req_addr == $past(req_addr)) |=> rsp_hit);
endmodule

// File: tb/tb_assoc_cache.sv
module tb_assoc_cache;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int CNT_W  = 16;
    localparam int LINES  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;

    logic [2:0]        rv, rh;
    logic [DATA_W-1:0] rd [3];
    logic [CNT_W-1:0]  mc [3];

    int total = 0;
    int bad   = 0;

    // Reference state: per config and set, a list of block addresses, most recent first.
    int q [12][$];
    bit ev [3];
    bit eh [3];
    int em [3];
    logic [DATA_W-1:0] ed;

    always #4 clk = ~clk;

    assoc_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WAYS(1), .CNT_W(CNT_W)) dut_dm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rv[0]), .rsp_hit(rh[0]), .rsp_data(rd[0]), .miss_count(mc[0]));
    assoc_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WAYS(2), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rv[1]), .rsp_hit(rh[1]), .rsp_data(rd[1]), .miss_count(mc[1]));
    assoc_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WAYS(4), .CNT_W(CNT_W)) dut_fa (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rv[2]), .rsp_hit(rh[2]), .rsp_data(rd[2]), .miss_count(mc[2]));

    task automatic chk(bit ok, string what, int c, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s cfg%0d act=%0d exp=%0d", what, c, act, exp);
        end
    endtask

    function automatic int ways_of(int c);
        return (c == 0) ? 1 : (c == 1) ? 2 : 4;
    endfunction

    // Behavioural LRU list model; returns 1 on hit.
    function automatic bit model_access(int c, int a);
        int w   = ways_of(c);
        int s   = a % (LINES / w);
        int idx = c * 4 + s;
        for (int i = 0; i < q[idx].size(); i++) begin
            if (q[idx][i] == a) begin
                q[idx].delete(i);
                q[idx].push_front(a);
                return 1'b1;
            end
        end
        if (q[idx].size() >= w) void'(q[idx].pop_back());
        q[idx].push_front(a);
        return 1'b0;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < 12; i++) q[i].delete();
        for (int c = 0; c < 3; c++) begin
            ev[c] = 1'b0;
            eh[c] = 1'b0;
            em[c] = 0;
        end
    endtask

    task automatic check_all();
        for (int c = 0; c < 3; c++) begin
            chk(rv[c] === ev[c], "R6 rsp_valid", c, rv[c], ev[c]);
            if (ev[c]) begin
                // R1 R2 R3 R4 R5 R10: hit bit against the recency model
                chk(rh[c] === eh[c], "R1/R2/R3/R4/R5/R10 rsp_hit", c, rh[c], eh[c]);
                chk(rd[c] === ed, "R8 rsp_data", c, rd[c], ed);
            end
            chk(mc[c] === CNT_W'(em[c]), "R7 miss_count", c, mc[c], em[c]);
        end
    endtask

    task automatic step(bit v, int a);
        @(negedge clk);
        check_all();
        req_valid = v;
        req_addr  = ADDR_W'(a);
        for (int c = 0; c < 3; c++) begin
            ev[c] = v;
            if (v) begin
                eh[c] = model_access(c, a);
                if (!eh[c]) em[c]++;
            end
        end
        if (v) ed = DATA_W'(a * 37 + 5);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n     = 1'b0;
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        for (int c = 0; c < 3; c++) begin
            chk(rv[c] === 1'b0, "R9 rsp_valid in reset", c, rv[c], 0);
            chk(mc[c] === '0, "R9 miss_count in reset", c, mc[c], 0);
        end
        model_clear();
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        model_clear();
        do_reset();

        // R11: placement comparison trace
        step(1, 0); step(1, 8); step(1, 0); step(1, 6); step(1, 8);
        step(0, 0);
        chk(mc[0] === CNT_W'(5), "R11 direct-mapped misses", 0, mc[0], 5);
        chk(mc[1] === CNT_W'(4), "R11 two-way misses", 1, mc[1], 4);
        chk(mc[2] === CNT_W'(3), "R11 fully associative misses", 2, mc[2], 3);
        step(0, 0);

        // R3 R5: fully associative order 0,1,2,3, touch 0, bring 4 -> 1 evicted
        do_reset();
        step(1, 0); step(1, 1); step(1, 2); step(1, 3);
        step(1, 0); step(1, 4); step(1, 1); step(1, 0);
        step(0, 0); step(0, 0);

        // R10: back-to-back repeats and conflicts
        step(1, 5); step(1, 5); step(1, 9); step(1, 5); step(1, 13); step(1, 13);
        step(0, 0);

        // Mixed stream with idle gaps (R6) over a small address range
        for (int n = 0; n < 3000; n++) begin
            int a;
            bit v;
            v = ($urandom_range(0, 3) != 0);
            a = ($urandom_range(0, 4) == 0) ? int'(req_addr) : int'($urandom_range(0, 15));
            step(v, a);
        end
        step(0, 0);

        // R9: reset in the middle of traffic invalidates every way
        do_reset();
        step(1, 0); step(1, 0);
        step(0, 0); step(0, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule